// File: doc/BRIEF.md
# Serial Register Target with Alert Response

This block is a two-wire serial bus target (I2C/SMBus compatible) that puts a small register file behind a fixed 7-bit bus address. It oversamples SCL and SDA on the system clock and finds START, repeated START and STOP. It drives SDA only by pulling it low. In a write transaction the first byte after the address loads a register pointer, and each further byte is written to the pointed register. In a read transaction the master first sets the pointer with a write, then issues a repeated START with the read bit. The block then returns bytes from the pointed register onward. The pointer advances after every data byte, in both directions, and wraps from the last register back to zero.

The block also takes part in the bus alert procedure. While user logic holds `alert_i` high, the block acknowledges the shared alert response address with the read bit set. It then returns its own address byte. After that byte is sent it emits a one-cycle `alert_clr_o` pulse, so user logic can drop the alert. The registers live in user logic. They are reached through a pointer output, a write strobe with data, and a read-data input that the block samples when it loads each outgoing byte.

Top module: `i2c_alert_target`

## Requirements
- R1: While reset is held and in the cycle after it, `sda_pull_o`, `reg_we_o` and `alert_clr_o` are low. `reg_addr_o` reads 0 after reset.
- R2: An address byte of 0xC8 (address 1100100, write) or 0xC9 (read) is acknowledged by pulling SDA low in the ninth clock. Any other address byte gets no acknowledge, and the block then leaves SDA released and makes no register write until the next START or STOP.
- R3: In a write, the byte after the address loads the register pointer from its low bits and is acknowledged.
- R4: Each later byte of a write is acknowledged and gives one single-cycle `reg_we_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The pointer then advances by one.
- R5: Register 0 is the read-only status register. A data byte aimed at it is acknowledged and produces no write strobe, and the pointer still advances.
- R6: After a repeated START with address 0xC9, the block sends the register at the pointer, most significant bit first, and the pointer advances after each byte sent.
- R7: A master acknowledge (SDA low) after a sent byte makes the block send the next register. A not-acknowledge makes it release SDA and keep SDA released until the next START or STOP.
- R8: The pointer wraps from the last register (3 with the default of four registers) to 0.
- R9: With `alert_i` high, the byte 0x19 (alert response address 0001100, read) is acknowledged, and the block returns the byte 0xC9.
- R10: With `alert_i` low, the byte 0x19 is not acknowledged.
- R11: `alert_clr_o` pulses for exactly one cycle, once per alert response. The pulse comes in the acknowledge clock that follows the returned address byte.
- R12: `sda_pull_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain drive) |
| alert_i | input | 1 | Alert pending from user logic |
| alert_clr_o | output | 1 | One-cycle pulse: alert address byte was delivered |
| reg_addr_o | output | PTR_W | Current register pointer |
| reg_we_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Read data of register `reg_addr_o` |

## Verification
The bench runs a burst write that ends on the last register and then a four-byte read that crosses the wrap. A pointer that failed to wrap, or that advanced before the write strobe, would put data in the wrong register or return the wrong byte. A write aimed at the status register is followed by one more byte, which shows that a design blocking the write but not advancing the pointer puts the next byte in the wrong place. After a master NACK and after a foreign address, the bench keeps clocking the bus and checks that SDA stays free and nothing is written, which catches a design that keeps transmitting or acknowledging. The alert address is tried with the alert low, where it must get a NACK, and with the alert high, where it must return 0xC9 and give exactly one clear pulse.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam logic [6:0] DEV_ADDR  = 7'b1100100;
    localparam logic [6:0] ALRT_ADDR = 7'b0001100;
    localparam int         STATUS_IDX = 0;
    localparam int         BIT_ACK   = 8;
    localparam int         BIT_LAST  = 9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WDAT,
        PH_RDAT,
        PH_ALRT,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        ADR_NONE,
        ADR_WRITE,
        ADR_READ,
        ADR_ALRT
    } adr_kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic adr_kind_e classify(input logic [7:0] b, input logic alert);
        if (b[7:1] == DEV_ADDR)
            return b[0] ? ADR_READ : ADR_WRITE;
        else if (b == {ALRT_ADDR, 1'b1} && alert)
            return ADR_ALRT;
        else
            return ADR_NONE;
    endfunction

endpackage

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_p;
    logic                   sda_p;
    logic                   scl_s;
    logic                   sda_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev_o.rise  = scl_s & ~scl_p;
        ev_o.fall  = ~scl_s & scl_p;
        ev_o.start = scl_s & scl_p & sda_p & ~sda_s;
        ev_o.stop  = scl_s & scl_p & ~sda_p & sda_s;
        ev_o.sda   = sda_s;
    end
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
    parameter int NUM_REGS = 4,
    parameter int PTR_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [PTR_W-1:0] load_val_i,
    input  logic             inc_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            ptr_o <= '0;
        else if (load_i)
            ptr_o <= load_val_i;
        else if (inc_i)
            ptr_o <= (ptr_o >= LAST) ? '0 : ptr_o + 1'b1;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev_i,
    input  logic             alert_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [7:0]       rdata_i,
    output logic             sda_pull_o,
    output logic             we_o,
    output logic [7:0]       wdata_o,
    output logic             ptr_load_o,
    output logic [PTR_W-1:0] ptr_val_o,
    output logic             ptr_inc_o,
    output logic             alert_clr_o
);
    localparam logic [PTR_W-1:0] STATUS_PTR = PTR_W'(STATUS_IDX);

    phase_e    phase;
    adr_kind_e kind;
    logic [3:0] cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       ack_q;
    logic       mack_q;
    logic [7:0] rx_byte;

    assign rx_byte = {rx_sh[6:0], ev_i.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            kind        <= ADR_NONE;
            cnt         <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            ack_q       <= 1'b0;
            mack_q      <= 1'b0;
            sda_pull_o  <= 1'b0;
            we_o        <= 1'b0;
            wdata_o     <= '0;
            ptr_load_o  <= 1'b0;
            ptr_val_o   <= '0;
            ptr_inc_o   <= 1'b0;
            alert_clr_o <= 1'b0;
        end else begin
            we_o        <= 1'b0;
            ptr_load_o  <= 1'b0;
            ptr_inc_o   <= 1'b0;
            alert_clr_o <= 1'b0;
            if (ev_i.stop) begin
                phase      <= PH_IDLE;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
            end else if (ev_i.start) begin
                phase      <= PH_ADDR;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
            end else if (phase != PH_IDLE && phase != PH_SKIP) begin
                if (ev_i.rise) begin
                    if (cnt < 4'(BIT_LAST))
                        cnt <= cnt + 4'd1;
                    if (cnt < 4'(BIT_ACK))
                        rx_sh <= rx_byte;
                    if (cnt == 4'd7) begin
                        case (phase)
                            PH_ADDR: begin
                                kind  <= classify(rx_byte, alert_i);
                                ack_q <= (classify(rx_byte, alert_i) != ADR_NONE);
                            end
                            PH_PTR: begin
                                ack_q      <= 1'b1;
                                ptr_load_o <= 1'b1;
                                ptr_val_o  <= rx_byte[PTR_W-1:0];
                            end
                            PH_WDAT: begin
                                ack_q     <= 1'b1;
                                ptr_inc_o <= 1'b1;
                                wdata_o   <= rx_byte;
                                we_o      <= (ptr_i != STATUS_PTR);
                            end
                            default: ack_q <= 1'b0;
                        endcase
                    end
                    if (cnt == 4'(BIT_ACK)) begin
                        if (phase == PH_RDAT) begin
                            ptr_inc_o <= 1'b1;
                            mack_q    <= ~ev_i.sda;
                        end
                        if (phase == PH_ALRT)
                            alert_clr_o <= 1'b1;
                    end
                end else if (ev_i.fall) begin
                    if (cnt == 4'(BIT_LAST)) begin
                        cnt <= '0;
                        sda_pull_o <= 1'b0;
                        case (phase)
                            PH_ADDR: begin
                                if (!ack_q)
                                    phase <= PH_SKIP;
                                else begin
                                    case (kind)
                                        ADR_WRITE: phase <= PH_PTR;
                                        ADR_READ: begin
                                            phase      <= PH_RDAT;
                                            tx_sh      <= rdata_i;
                                            sda_pull_o <= ~rdata_i[7];
                                        end
                                        ADR_ALRT: begin
                                            phase      <= PH_ALRT;
                                            tx_sh      <= {DEV_ADDR, 1'b1};
                                            sda_pull_o <= ~DEV_ADDR[6];
                                        end
                                        default: phase <= PH_SKIP;
                                    endcase
                                end
                            end
                            PH_PTR:  phase <= PH_WDAT;
                            PH_WDAT: phase <= PH_WDAT;
                            PH_RDAT: begin
                                if (mack_q) begin
                                    tx_sh      <= rdata_i;
                                    sda_pull_o <= ~rdata_i[7];
                                end else
                                    phase <= PH_SKIP;
                            end
                            default: phase <= PH_SKIP;
                        endcase
                    end else if (cnt == 4'(BIT_ACK)) begin
                        if (phase == PH_RDAT || phase == PH_ALRT)
                            sda_pull_o <= 1'b0;
                        else
                            sda_pull_o <= ack_q;
                    end else if (cnt != 4'd0 && (phase == PH_RDAT || phase == PH_ALRT)) begin
                        sda_pull_o <= ~tx_sh[6];
                        tx_sh      <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_alert_target.sv
module i2c_alert_target
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic             alert_i,
    output logic             alert_clr_o,
    output logic [PTR_W-1:0] reg_addr_o,
    output logic             reg_we_o,
    output logic [7:0]       reg_wdata_o,
    input  logic [7:0]       reg_rdata_i
);
    bus_ev_t          ev;
    logic             ptr_load;
    logic [PTR_W-1:0] ptr_val;
    logic             ptr_inc;

    i2c_tgt_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_tgt_ptr #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ptr_load),
        .load_val_i (ptr_val),
        .inc_i      (ptr_inc),
        .ptr_o      (reg_addr_o)
    );

    i2c_tgt_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (ev),
        .alert_i     (alert_i),
        .ptr_i       (reg_addr_o),
        .rdata_i     (reg_rdata_i),
        .sda_pull_o  (sda_pull_o),
        .we_o        (reg_we_o),
        .wdata_o     (reg_wdata_o),
        .ptr_load_o  (ptr_load),
        .ptr_val_o   (ptr_val),
        .ptr_inc_o   (ptr_inc),
        .alert_clr_o (alert_clr_o)
    );
endmodule

// File: rtl/i2c_alert_target_chk.sv
module i2c_alert_target_chk #(
    parameter int NUM_REGS = 4,
    parameter int PTR_W    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_i,
    input logic             alert_i,
    input logic             sda_pull_o,
    input logic             alert_clr_o,
    input logic             reg_we_o,
    input logic [PTR_W-1:0] reg_addr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!sda_pull_o && !reg_we_o && !alert_clr_o)); // R1
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_pull_o) |-> !scl_i); // R12
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) reg_we_o |=> !reg_we_o); // R4
    AST_NO_STATUS_WR: assert property (@(posedge clk) disable iff (rst) reg_we_o |-> (reg_addr_o != '0)); // R5
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst) (reg_we_o && reg_addr_o == LAST) |=> (reg_addr_o == '0)); // R8
    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) alert_clr_o |=> !alert_clr_o); // R11
    AST_CLR_NEEDS_ALERT: assert property (@(posedge clk) disable iff (rst) alert_clr_o |-> alert_i); // R9
endmodule

bind i2c_alert_target i2c_alert_target_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .alert_i     (alert_i),
    .sda_pull_o  (sda_pull_o),
    .alert_clr_o (alert_clr_o),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o)
);

// File: tb/test_i2c_alert_target.sv
`timescale 1ns/1ps
module test_i2c_alert_target;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       alert = 1'b0;
    logic       sda_pull;
    logic       alert_clr;
    logic [1:0] reg_addr;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sda_bus;
    logic [7:0] regs [4];
    int         n_tests = 0;
    int         n_fail = 0;
    int         we_cnt = 0;
    int         clr_cnt = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_pull;
    assign reg_rdata = regs[reg_addr];

    i2c_alert_target i_i2c_alert_target (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_pull_o  (sda_pull),
        .alert_i     (alert),
        .alert_clr_o (alert_clr),
        .reg_addr_o  (reg_addr),
        .reg_we_o    (reg_we),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            regs[0] <= 8'h81;
            regs[1] <= 8'h00;
            regs[2] <= 8'h00;
            regs[3] <= 8'h00;
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (!rst && alert_clr)
            clr_cnt <= clr_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_bus;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 sda_pull after reset", sda_pull, 0);
        chk("R1 reg_we after reset", reg_we, 0);
        chk("R1 alert_clr after reset", alert_clr, 0);
        chk("R1 reg_addr after reset", reg_addr, 0);
    endtask

    task automatic t_burst_write();
        logic ack;
        int w0;
        w0 = we_cnt;
        bus_start();
        send_byte(8'hC8, ack); chk("R2 ack of write address", ack, 1);
        send_byte(8'h02, ack); chk("R3 ack of pointer", ack, 1);
        send_byte(8'hF0, ack); chk("R4 ack of first data", ack, 1);
        send_byte(8'h01, ack); chk("R4 ack of second data", ack, 1);
        bus_stop();
        chk("R4 reg2 written", regs[2], 8'hF0);
        chk("R4 reg3 written", regs[3], 8'h01);
        chk("R4 strobe count", we_cnt - w0, 2);
        chk("R8 pointer wrapped to 0", reg_addr, 0);
    endtask

    task automatic t_status_write();
        logic ack;
        int w0;
        w0 = we_cnt;
        bus_start();
        send_byte(8'hC8, ack); chk("R2 ack of write address", ack, 1);
        send_byte(8'h00, ack); chk("R3 ack of pointer 0", ack, 1);
        send_byte(8'h55, ack); chk("R5 status write acked", ack, 1);
        send_byte(8'hAA, ack); chk("R5 next byte acked", ack, 1);
        bus_stop();
        chk("R5 status unchanged", regs[0], 8'h81);
        chk("R5 pointer advanced past status", regs[1], 8'hAA);
        chk("R5 one strobe only", we_cnt - w0, 1);
    endtask

    task automatic t_read();
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hC8, ack); chk("R2 ack of write address", ack, 1);
        send_byte(8'h02, ack); chk("R3 ack of pointer", ack, 1);
        bus_rstart();
        send_byte(8'hC9, ack); chk("R2 ack of read address", ack, 1);
        recv_byte(1'b1, b); chk("R6 first read byte", b, 8'hF0);
        recv_byte(1'b1, b); chk("R7 second read byte", b, 8'h01);
        recv_byte(1'b1, b); chk("R8 read wraps to status", b, 8'h81);
        recv_byte(1'b0, b); chk("R6 last read byte", b, 8'hAA);
        tick(Q); scl_m = 1'b1; tick(Q);
        chk("R7 SDA released after NACK", sda_bus, 1);
        tick(Q); scl_m = 1'b0; tick(Q);
        chk("R7 no pull after NACK", sda_pull, 0);
        bus_stop();
        chk("R6 pointer after four reads", reg_addr, 2);
    endtask

    task automatic t_foreign_addr();
        logic ack;
        int w0;
        w0 = we_cnt;
        bus_start();
        send_byte(8'hA0, ack); chk("R2 foreign address not acked", ack, 0);
        send_byte(8'h00, ack); chk("R2 later byte ignored", ack, 0);
        bus_stop();
        chk("R2 no write after foreign address", we_cnt - w0, 0);
    endtask

    task automatic t_alert_idle();
        logic ack;
        alert = 1'b0;
        bus_start();
        send_byte(8'h19, ack); chk("R10 alert address NACK without alert", ack, 0);
        bus_stop();
        chk("R10 no clear pulse", clr_cnt, 0);
    endtask

    task automatic t_alert_resp();
        logic ack;
        logic [7:0] b;
        int c0;
        c0 = clr_cnt;
        alert = 1'b1;
        tick(Q);
        bus_start();
        send_byte(8'h19, ack); chk("R9 alert address acked", ack, 1);
        recv_byte(1'b0, b); chk("R9 returned own address", b, 8'hC9);
        chk("R11 one clear pulse", clr_cnt - c0, 1);
        alert = 1'b0;
        bus_stop();
        chk("R11 still one clear pulse", clr_cnt - c0, 1);
        chk("R12 SDA free at end", sda_pull, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_burst_write();
        t_status_write();
        t_read();
        t_foreign_addr();
        t_alert_idle();
        t_alert_resp();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule